// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block issues one SD-card command in SPI mode and returns the card's one-byte status reply. A caller presents a 6-bit command index, a 32-bit argument and a check byte, then pulses `start`. The block pulls chip select low and shifts out the six-byte command frame through its own byte-wide SPI master (mode 0, MSB first). It then keeps clocking filler bytes of all ones until the card answers with a byte whose top bit is clear. That byte is reported as the status. If no such byte comes within a bounded number of polls, the block reports a timeout with an all-ones status.

In the normal flow the block releases chip select once the command finishes, sends one further filler byte with the card deselected, and then pulses `done`. Some commands are followed by more data, such as an operating-conditions word or a register block. For these the caller sets `keep_sel`. A successful reply then leaves the card selected. The caller pulls trailer bytes one at a time with `rd_req` and ends the exchange with `rel_req`, which performs the same deselect-and-filler step. A timeout always performs the release, whatever `keep_sel` says.

Top module: `sd_cmd_engine`

## Requirements
- R1: The frame holds six bytes, sent in this order: `0x40 | cmd_idx`, then `cmd_arg[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, then the check byte.
- R2: When `crc_en` is 1 the sixth byte is `crc_byte`. When `crc_en` is 0 it is the fixed value 0x95.
- R3: `cs_n` goes low before the first SCK rising edge of the frame and stays low through the frame and all polling.
- R4: The SPI link runs in mode 0. SCK idles low, MOSI changes only when SCK falls, MISO is sampled when SCK rises, and each byte is sent MSB first. One SCK half-period lasts `CLK_DIV` system clocks.
- R5: After the frame, the block clocks 0xFF bytes until it receives a byte with bit 7 clear. That byte appears on `r1` with `timeout` = 0.
- R6: If `POLL_LIMIT` polled bytes in a row all have bit 7 set, the block stops polling and reports `timeout` = 1 and `r1` = 0xFF.
- R7: With `keep_sel` = 0, completion raises `cs_n` and then clocks exactly one byte of eight ones with `cs_n` high before `done` pulses.
- R8: With `keep_sel` = 1 and a valid reply, `done` pulses while `cs_n` stays low and `held` = 1. Each `rd_req` clocks one 0xFF byte and returns the received byte on `rd_data` together with a one-cycle `rd_valid`. `rel_req` raises `cs_n`, clocks one byte of ones, and returns the block to idle without another `done`.
- R9: With `keep_sel` = 1 and a timeout, the block releases exactly as in R7.
- R10: `start` is ignored while `busy` or `held` is high. The frame in progress is unchanged, and no bytes are clocked while the card is held.
- R11: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted `start` until the block is back to idle.
- R12: After reset, `cs_n` = 1, `sck` = 0, `done` = 0, `busy` = 0 and `held` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (pulse) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_byte | input | 8 | Check byte used when `crc_en` = 1 |
| crc_en | input | 1 | 1: send `crc_byte`; 0: send 0x95 |
| keep_sel | input | 1 | Keep card selected after a valid reply |
| rd_req | input | 1 | While held, read one trailer byte |
| rel_req | input | 1 | While held, release the card |
| miso | input | 1 | Serial data from card |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to card |
| r1 | output | 8 | Status reply byte |
| timeout | output | 1 | No reply within the poll limit |
| done | output | 1 | Command complete (one cycle) |
| busy | output | 1 | Command or hold in progress |
| held | output | 1 | Card left selected for trailer reads |
| rd_data | output | 8 | Trailer byte read while held |
| rd_valid | output | 1 | `rd_data` updated (one cycle) |

## Verification
The assertions check the following on every cycle: chip select stays low during the frame and polling, MOSI changes only when SCK falls, and SCK stays quiet when no byte is in flight. They also check that a completed reply has bit 7 clear, or else carries an all-ones status and a released select after a timeout; that `done` lasts one cycle; that a held card stays selected; that a start request during a hold is ignored; and that the poll count never passes its limit. Several behaviours are visible only in the bench's scenarios, which play the card side: the exact frame contents, the number of filler bytes sent before a reply, the count of SCK edges with the card deselected, the exact poll index at which a timeout begins, and the trailer bytes returned while held.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_TAIL,
    ST_HOLD,
    ST_READ
  } sdc_state_e;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] FIXED_CRC  = 8'h95;
  localparam logic [1:0] CMD_PREFIX = 2'b01;
  localparam int         FRAME_LAST = 5;
endpackage

// File: rtl/sdc_byte_shifter.sv
module sdc_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(CLK_DIV - 1);

  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic          sck_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= 8'hFF;
      rx_sh  <= 8'h00;
      bit_q  <= '0;
      div_q  <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !busy_q) begin
        busy_q <= 1'b1;
        tx_sh  <= tx;
        bit_q  <= '0;
        div_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DIV_END) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_sh <= {tx_sh[6:0], 1'b1};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = tx_sh[7];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_sh;

  // R4: data line moves only together with a falling clock edge
  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_q) && busy_q && !$stable(tx_sh[7])) |-> $fell(sck_q));
  // R4: serial clock stays low with no byte in flight
  a_r4_sck_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !go) |=> !sck_q);
endmodule

// File: rtl/sdc_poll_ctr.sv
module sdc_poll_ctr #(
  parameter int POLL_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc && cnt_q != CNT_END) cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CNT_END);

  // R6: poll count never runs past its limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < POLL_LIMIT);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [7:0]  crc_byte,
  input  logic        crc_en,
  input  logic        keep_sel,
  input  logic        rd_req,
  input  logic        rel_req,
  input  logic        miso,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  output logic [7:0]  r1,
  output logic        timeout,
  output logic        done,
  output logic        busy,
  output logic        held,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  sdc_state_e  st;
  logic [39:0] frame_q;
  logic [2:0]  nbyte_q;
  logic        go_q;
  logic [7:0]  tx_q;
  logic        keep_q;
  logic        rel_q;
  logic        cs_q;
  logic [7:0]  r1_q;
  logic        to_q;
  logic        done_q;
  logic [7:0]  rdd_q;
  logic        rdv_q;

  logic        sh_busy;
  logic        sh_done;
  logic [7:0]  sh_rx;
  logic        pc_clr;
  logic        pc_inc;
  logic        pc_last;

  sdc_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .go   (go_q),
    .tx   (tx_q),
    .miso (miso),
    .sck  (sck),
    .mosi (mosi),
    .busy (sh_busy),
    .done (sh_done),
    .rx   (sh_rx)
  );

  sdc_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk  (clk),
    .rst  (rst),
    .clr  (pc_clr),
    .inc  (pc_inc),
    .last (pc_last)
  );

  always_comb begin
    pc_clr = (st == ST_FRAME) && sh_done && (nbyte_q == 3'(FRAME_LAST));
    pc_inc = (st == ST_POLL) && sh_done && sh_rx[7] && !pc_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      frame_q <= '0;
      nbyte_q <= '0;
      go_q    <= 1'b0;
      tx_q    <= FILL_BYTE;
      keep_q  <= 1'b0;
      rel_q   <= 1'b0;
      cs_q    <= 1'b1;
      r1_q    <= FILL_BYTE;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
      rdd_q   <= '0;
      rdv_q   <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            frame_q <= {cmd_arg, (crc_en ? crc_byte : FIXED_CRC)};
            tx_q    <= {CMD_PREFIX, cmd_idx};
            nbyte_q <= '0;
            keep_q  <= keep_sel;
            cs_q    <= 1'b0;
            go_q    <= 1'b1;
            st      <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (sh_done) begin
            go_q <= 1'b1;
            if (nbyte_q == 3'(FRAME_LAST)) begin
              tx_q <= FILL_BYTE;
              st   <= ST_POLL;
            end else begin
              tx_q    <= frame_q[39:32];
              frame_q <= {frame_q[31:0], 8'h00};
              nbyte_q <= nbyte_q + 3'd1;
            end
          end
        end
        ST_POLL: begin
          if (sh_done) begin
            if (!sh_rx[7]) begin
              r1_q <= sh_rx;
              to_q <= 1'b0;
              if (keep_q) begin
                done_q <= 1'b1;
                st     <= ST_HOLD;
              end else begin
                cs_q  <= 1'b1;
                tx_q  <= FILL_BYTE;
                go_q  <= 1'b1;
                rel_q <= 1'b0;
                st    <= ST_TAIL;
              end
            end else if (pc_last) begin
              r1_q  <= FILL_BYTE;
              to_q  <= 1'b1;
              cs_q  <= 1'b1;
              tx_q  <= FILL_BYTE;
              go_q  <= 1'b1;
              rel_q <= 1'b0;
              st    <= ST_TAIL;
            end else begin
              tx_q <= FILL_BYTE;
              go_q <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (sh_done) begin
            if (!rel_q) done_q <= 1'b1;
            st <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (rd_req) begin
            tx_q <= FILL_BYTE;
            go_q <= 1'b1;
            st   <= ST_READ;
          end else if (rel_req) begin
            cs_q  <= 1'b1;
            tx_q  <= FILL_BYTE;
            go_q  <= 1'b1;
            rel_q <= 1'b1;
            st    <= ST_TAIL;
          end
        end
        ST_READ: begin
          if (sh_done) begin
            rdd_q <= sh_rx;
            rdv_q <= 1'b1;
            st    <= ST_HOLD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cs_n     = cs_q;
  assign r1       = r1_q;
  assign timeout  = to_q;
  assign done     = done_q;
  assign busy     = (st != ST_IDLE);
  assign held     = (st == ST_HOLD) || (st == ST_READ);
  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;

  // R3: card selected for the whole frame and poll phase
  a_r3_cs_low_in_frame: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAME || st == ST_POLL) |-> !cs_q);
  // R5: a reported reply has its top bit clear
  a_r5_reply_msb_clear: assert property (@(posedge clk) disable iff (rst)
    (done_q && !to_q) |-> !r1_q[7]);
  // R6: a timeout reports all ones
  a_r6_timeout_all_ones: assert property (@(posedge clk) disable iff (rst)
    (done_q && to_q) |-> (r1_q == 8'hFF));
  // R9: a timeout always ends deselected
  a_r9_timeout_released: assert property (@(posedge clk) disable iff (rst)
    (done_q && to_q) |-> cs_q);
  // R8: a held card stays selected
  a_r8_hold_selected: assert property (@(posedge clk) disable iff (rst)
    held |-> !cs_q);
  // R10: start during a hold changes nothing
  a_r10_hold_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && start && !rd_req && !rel_req) |=> (st == ST_HOLD));
  // R11: completion flag lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  localparam int DIV   = 2;
  localparam int LIMIT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  crc_byte = '0;
  logic        crc_en = 1'b0;
  logic        keep_sel = 1'b0;
  logic        rd_req = 1'b0;
  logic        rel_req = 1'b0;
  logic        miso;
  logic        cs_n, sck, mosi, timeout, done, busy, held, rd_valid;
  logic [7:0]  r1, rd_data;

  always #5 clk = ~clk;

  sd_cmd_engine #(.CLK_DIV(DIV), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .crc_byte(crc_byte), .crc_en(crc_en), .keep_sel(keep_sel), .rd_req(rd_req),
    .rel_req(rel_req), .miso(miso), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .r1(r1), .timeout(timeout), .done(done), .busy(busy), .held(held),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int fails = 0;

  // card model state
  int         s_delay = 0;
  logic [7:0] s_resp = 8'h00;
  int         scnt = 0;
  logic [7:0] cap_sh = 8'h00;
  int         cap_bits = 0;
  int         cap_n = 0;
  logic [7:0] cap_bytes [0:63];
  int         hi_edges = 0;
  int         hi_ones = 0;
  int         done_cnt = 0;

  function automatic logic [7:0] card_byte(int k);
    int p;
    if (k < 6) return 8'hFF;
    p = k - 6;
    if (p < s_delay) return 8'h80 | 8'((p * 29 + 5) & 8'h7F);
    if (p == s_delay) return s_resp;
    return 8'hA0 + 8'(p - s_delay - 1);
  endfunction

  always_comb begin
    logic [7:0] cb;
    cb = card_byte(scnt / 8);
    miso = cs_n ? 1'b1 : cb[7 - (scnt % 8)];
  end

  always @(negedge sck or posedge cs_n) begin
    if (cs_n) scnt = 0;
    else scnt = scnt + 1;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      cap_sh = {cap_sh[6:0], mosi};
      cap_bits = cap_bits + 1;
      if (cap_bits == 8) begin
        if (cap_n < 64) cap_bytes[cap_n] = cap_sh;
        cap_n = cap_n + 1;
        cap_bits = 0;
      end
    end else begin
      hi_edges = hi_edges + 1;
      if (mosi) hi_ones = hi_ones + 1;
    end
  end

  always @(posedge clk) if (done === 1'b1) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(logic [5:0] c, logic [31:0] a, logic [7:0] cr, logic ce, int i);
    case (i)
      0: return 8'h40 | {2'b00, c};
      1: return a[31:24];
      2: return a[23:16];
      3: return a[15:8];
      4: return a[7:0];
      default: return ce ? cr : 8'h95;
    endcase
  endfunction

  task automatic wait_sig(input int which, input string req);
    int n = 0;
    bit hit = 0;
    while (!hit && n < 4000) begin
      @(negedge clk);
      n++;
      case (which)
        0: hit = (done === 1'b1);
        1: hit = (rd_valid === 1'b1);
        default: hit = (busy === 1'b0);
      endcase
    end
    if (!hit) chk(1'b0, {req, " watchdog"}, 32'(n), 32'd0);
  endtask

  task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input logic [7:0] cr,
                         input logic ce, input logic kp, input int d, input logic [7:0] rsp,
                         input bit poke_start);
    int dc0;
    bit to_exp;
    int nlow;
    logic [7:0] r1_exp;
    s_delay = d; s_resp = rsp;
    cap_n = 0; cap_bits = 0; hi_edges = 0; hi_ones = 0;
    dc0 = done_cnt;
    to_exp = (d >= LIMIT);
    r1_exp = to_exp ? 8'hFF : rsp;
    nlow = 6 + (to_exp ? LIMIT : d + 1);
    @(negedge clk);
    cmd_idx = c; cmd_arg = a; crc_byte = cr; crc_en = ce; keep_sel = kp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R11 busy after start", 32'(busy), 32'd1);
    if (poke_start) begin
      repeat (40) @(negedge clk);
      cmd_idx = ~c; cmd_arg = ~a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_sig(0, "R5 done");
    chk(r1 === r1_exp, to_exp ? "R6 timeout reply" : "R5 reply", 32'(r1), 32'(r1_exp));
    chk(timeout === to_exp, "R6 timeout flag", 32'(timeout), 32'(to_exp));
    for (int i = 0; i < 6; i++) begin
      logic [7:0] fe;
      fe = frame_byte(c, a, cr, ce, i);
      chk(cap_bytes[i] === fe, (i == 5) ? "R2 check byte" :
          (poke_start ? "R10 frame kept" : "R1 frame byte"), 32'(cap_bytes[i]), 32'(fe));
    end
    chk(cap_n == nlow, "R5 polled byte count", 32'(cap_n), 32'(nlow));
    for (int i = 6; i < nlow && i < 64; i++)
      if (cap_bytes[i] !== 8'hFF) chk(1'b0, "R5 filler", 32'(cap_bytes[i]), 32'hFF);
    if (kp && !to_exp) begin
      chk(cs_n === 1'b0 && held === 1'b1, "R8 held selected", {30'd0, cs_n, held}, 32'd1);
      chk(hi_edges == 0, "R8 no release byte", 32'(hi_edges), 32'd0);
      for (int r = 0; r < 2; r++) begin
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        wait_sig(1, "R8 read");
        chk(rd_data === 8'hA0 + 8'(r), "R8 trailer byte", 32'(rd_data), 32'(8'hA0 + 8'(r)));
      end
      nlow = cap_n;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      chk(held === 1'b1 && cs_n === 1'b0, "R10 start ignored while held", {30'd0, held, cs_n}, 32'd2);
      chk(cap_n == nlow && hi_edges == 0, "R10 no bytes while held", 32'(cap_n), 32'(nlow));
      @(negedge clk); rel_req = 1'b1;
      @(negedge clk); rel_req = 1'b0;
      wait_sig(2, "R8 release");
      chk(cs_n === 1'b1 && held === 1'b0, "R8 release deselects", {30'd0, cs_n, held}, 32'd2);
      chk(hi_edges == 8 && hi_ones == 8, "R8 release byte", 32'(hi_edges), 32'd8);
      chk(done_cnt == dc0 + 1, "R8 no second done", 32'(done_cnt), 32'(dc0 + 1));
    end else begin
      chk(cs_n === 1'b1, kp ? "R9 timeout deselects" : "R7 deselected", 32'(cs_n), 32'd1);
      chk(hi_edges == 8 && hi_ones == 8, kp ? "R9 extra byte" : "R7 extra byte",
          32'(hi_edges * 100 + hi_ones), 32'd808);
      chk(busy === 1'b0, "R11 idle at done", 32'(busy), 32'd0);
      @(negedge clk);
      chk(done === 1'b0, "R11 done one cycle", 32'(done), 32'd0);
      chk(done_cnt == dc0 + 1, "R11 single done", 32'(done_cnt), 32'(dc0 + 1));
    end
  endtask

  initial begin
    void'($urandom(32'h5D1C0A7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R12 reset lines", {30'd0, cs_n, sck}, 32'd2);
    chk(done === 1'b0 && busy === 1'b0 && held === 1'b0, "R12 reset flags",
        {29'd0, done, busy, held}, 32'd0);
    // directed corner cases
    run_cmd(6'd0, 32'h0, 8'h00, 1'b0, 1'b0, 0, 8'h01, 0);                 // R2 fixed check byte
    run_cmd(6'd8, 32'h0000_01AA, 8'h87, 1'b1, 1'b0, 3, 8'h05, 0);         // R1 R2
    run_cmd(6'd17, 32'h1234_5678, 8'h00, 1'b0, 1'b0, LIMIT - 1, 8'h00, 0); // R6 last poll still valid
    run_cmd(6'd55, 32'hDEAD_BEEF, 8'h00, 1'b0, 1'b0, LIMIT, 8'h00, 0);     // R6 timeout
    run_cmd(6'd58, 32'h0, 8'hFD, 1'b1, 1'b1, 2, 8'h00, 0);                 // R8 hold
    run_cmd(6'd58, 32'h0, 8'h00, 1'b0, 1'b1, LIMIT + 3, 8'h00, 0);         // R9 hold timeout
    run_cmd(6'd41, 32'h4000_0000, 8'h00, 1'b0, 1'b0, 4, 8'h01, 1);         // R10 start while busy
    // random traffic
    for (int t = 0; t < 10; t++) begin
      logic [31:0] ra;
      int rd;
      ra = $urandom;
      rd = $urandom_range(0, LIMIT + 1);
      run_cmd(6'($urandom), ra, 8'($urandom), 1'($urandom), 1'($urandom), rd,
              8'($urandom) & 8'h7F, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule